// File: doc/BRIEF.md
# Trail Trace Message Monitor

The monitor takes in one trace byte per frame, already pulled out of the overhead by upstream logic. It finds where each repeating trace message starts and checks every byte against an expected message. The expected message sits in a RAM outside the block. The monitor drives that RAM's read address with its own byte position and reads the answer back in the same cycle.

Two modes find the message start from the top bits of the bytes. The 16-byte mode has one header byte followed by 15 identifier bytes. The 64-byte mode has one header byte followed by 63 identifier bytes. In both, the header byte's top bit is 1 and every identifier byte's top bit is 0. A third mode uses a 64-byte message that ends in carriage return and line feed. It finds the start by spotting that two-byte trailer.

Two single-byte modes need no alignment. The fixed-byte mode treats a constant expected byte as a 16-byte message with no alignment pattern. The free-byte mode only requires that the byte never changes, and no expected value is used.

While aligned, the monitor copies every received byte into a readable buffer at its position. It raises a mismatch flag when a byte differs from what is expected, and clears the flag once a whole message has arrived with no difference. The mode must not be changed while out of reset. A mode change takes effect through a reset.

Top module: `tti_monitor`

## Requirements
- R1: After reset, `locked` and `mismatch` are 0 in the three aligning modes, and every buffer entry reads 0.
- R2: In mode 0 (16-byte, top bits 1 then fifteen 0s), `locked` rises on the byte that completes a top-bit-1 byte followed by 15 top-bit-0 bytes. It is still 0 after only 15 of those 16 bytes.
- R3: In mode 1 (64-byte, top bits 1 then sixty-three 0s), `locked` rises on the 64th byte of such a run. It is still 0 after 63 bytes.
- R4: In modes 0 and 1, a locked monitor loses lock on the first byte whose top bit is wrong for its position, where position 0 expects 1 and all others expect 0.
- R5: In mode 2 (64-byte with trailer), `locked` rises on a 0x0A byte that directly follows a 0x0D byte. The next byte is taken as position 0.
- R6: In mode 2, a locked monitor loses lock if position 62 is not 0x0D or position 63 is not 0x0A.
- R7: While locked, `exp_addr` shows the position of the next byte. A byte that differs from `exp_data` sets `mismatch` on that byte.
- R8: `mismatch` stays set until the last byte of a message in which every byte matched. It clears on that last byte.
- R9: In mode 3 (fixed byte), `locked` is 1 from reset. Positions run 0 to 15 from the first byte after reset, and each byte is compared with `exp_data`.
- R10: In mode 4 (free byte), `locked` is 1, and `mismatch` is set by any byte that differs from the byte before it. The first byte after reset has no predecessor and sets nothing. The flag clears at the end of a 16-byte window with no change.
- R11: A byte received while locked is readable at `rd_data` when `rd_addr` equals its position.
- R12: Bytes received while unlocked are not compared and not stored, so `mismatch` and the buffer are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A new trace byte is on `byte_in` this cycle |
| byte_in | input | 8 | Received trace byte |
| mode | input | 3 | 0: 16-byte, 1: 64-byte, 2: 64-byte with trailer, 3: fixed byte, 4: free byte |
| exp_addr | output | 6 | Read address into the expected-message RAM (current position) |
| exp_data | input | 8 | Expected byte at `exp_addr`, same cycle |
| rd_addr | input | 6 | Read address into the accepted-message buffer |
| rd_data | output | 8 | Accepted byte at `rd_addr` |
| locked | output | 1 | Message alignment found |
| mismatch | output | 1 | Received message differs from the expected one |

## Verification
One clean message is run through each of the five modes. A second message then carries a single flipped low bit at one position, and a third message is clean. This separates a flag that sets on the faulty byte from one that sets late, and a clear at message end from a clear at any matching byte. Faults at position 0 and at the last position test the wrap of the position counter. Directed runs use sequences that are one byte short of a lock, a top bit set in the middle of a message, a trailer broken at position 62, and garbage before alignment. These separate correct lock timing from off-by-one lock, and show that unlocked bytes leave no trace.

// File: rtl/tti_pkg.sv
package tti_pkg;
  localparam int BW      = 8;
  localparam int MAX_LEN = 64;
  localparam int AW      = $clog2(MAX_LEN);
  localparam int SHORT_LEN = 16;
  localparam logic [BW-1:0] CH_CR = 8'h0D;
  localparam logic [BW-1:0] CH_LF = 8'h0A;

  typedef enum logic [2:0] {
    TTI_SHORT = 3'd0,
    TTI_LONG  = 3'd1,
    TTI_CRLF  = 3'd2,
    TTI_FIXED = 3'd3,
    TTI_FREE  = 3'd4
  } tti_mode_e;

  // Index of the final byte of one message period
  function automatic logic [AW-1:0] last_pos(tti_mode_e m);
    if (m == TTI_LONG || m == TTI_CRLF) return AW'(MAX_LEN - 1);
    return AW'(SHORT_LEN - 1);
  endfunction

  function automatic logic uses_msb(tti_mode_e m);
    return (m == TTI_SHORT) || (m == TTI_LONG);
  endfunction

  function automatic logic free_run(tti_mode_e m);
    return (m == TTI_FIXED) || (m == TTI_FREE);
  endfunction

  // Top bit that a byte at position p must carry
  function automatic logic msb_at(logic [AW-1:0] p);
    return (p == '0);
  endfunction

  function automatic logic [AW-1:0] step(logic [AW-1:0] p, logic [AW-1:0] last);
    return (p == last) ? '0 : p + AW'(1);
  endfunction
endpackage

// File: rtl/tti_align.sv
module tti_align
  import tti_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [BW-1:0] data,
  input  tti_mode_e     md,
  output logic          lock_r,
  output logic [AW-1:0] pos,
  output logic          at_last,
  output logic          msb_bad,
  output logic          lock_set,
  output logic          lock_drop
);
  logic          cand;
  logic          prev_cr;
  logic [AW-1:0] last;
  logic          crlf_bad;
  logic          msb_set;
  logic          crlf_set;

  assign last     = last_pos(md);
  assign at_last  = (pos == last);
  assign msb_bad  = uses_msb(md) && lock_r && (data[BW-1] != msb_at(pos));
  assign crlf_bad = (md == TTI_CRLF) && lock_r &&
                    (((pos == last - AW'(1)) && data != CH_CR) ||
                     (at_last && data != CH_LF));
  assign lock_drop = vld && (msb_bad || crlf_bad);
  assign msb_set   = uses_msb(md) && !lock_r && cand && !data[BW-1] && at_last;
  assign crlf_set  = (md == TTI_CRLF) && !lock_r && prev_cr && (data == CH_LF);
  assign lock_set  = vld && (msb_set || crlf_set);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_r  <= 1'b0;
      pos     <= '0;
      cand    <= 1'b0;
      prev_cr <= 1'b0;
    end else if (vld) begin
      prev_cr <= (data == CH_CR);
      if (free_run(md) || (lock_r && !lock_drop)) begin
        pos <= step(pos, last);
      end else if (uses_msb(md)) begin
        lock_r <= lock_set;
        if (data[BW-1]) begin
          cand <= 1'b1;
          pos  <= AW'(1);
        end else if (cand && !lock_r && !at_last) begin
          pos <= pos + AW'(1);
        end else begin
          cand <= 1'b0;
          pos  <= '0;
        end
      end else begin
        lock_r <= lock_set;
        pos    <= '0;
      end
    end
  end
endmodule

// File: rtl/tti_compare.sv
module tti_compare
  import tti_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic          vld,
  input  logic [BW-1:0] data,
  input  logic [BW-1:0] exp_data,
  input  tti_mode_e     md,
  input  logic          at_last,
  input  logic          lock_set,
  output logic          byte_diff,
  output logic          mm_clear,
  output logic          mismatch
);
  logic [BW-1:0] prev_byte;
  logic          have_prev;
  logic          msg_bad;

  assign byte_diff = (md == TTI_FREE) ? (have_prev && data != prev_byte)
                                      : (data != exp_data);
  assign mm_clear  = chk_en && at_last && !byte_diff && !msg_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_byte <= '0;
      have_prev <= 1'b0;
      msg_bad   <= 1'b0;
      mismatch  <= 1'b0;
    end else begin
      if (vld) begin
        prev_byte <= data;
        have_prev <= 1'b1;
      end
      if (lock_set) begin
        msg_bad <= 1'b0;
      end else if (chk_en) begin
        if (at_last) msg_bad <= 1'b0;
        else if (byte_diff) msg_bad <= 1'b1;
        if (byte_diff) mismatch <= 1'b1;
        else if (mm_clear) mismatch <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tti_capture.sv
module tti_capture
  import tti_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [BW-1:0] rd_data
);
  logic [BW-1:0] mem [MAX_LEN];

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) mem[g] <= '0;
      else if (wr_en && wr_addr == AW'(g)) mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tti_monitor.sv
module tti_monitor
  import tti_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [BW-1:0] byte_in,
  input  logic [2:0]    mode,
  output logic [AW-1:0] exp_addr,
  input  logic [BW-1:0] exp_data,
  input  logic [AW-1:0] rd_addr,
  output logic [BW-1:0] rd_data,
  output logic          locked,
  output logic          mismatch
);
  tti_mode_e     md;
  logic          lock_r;
  logic [AW-1:0] pos;
  logic          at_last;
  logic          msb_bad;
  logic          lock_set;
  logic          lock_drop;
  logic          chk_en;
  logic          byte_diff;
  logic          mm_clear;

  assign md       = tti_mode_e'(mode);
  assign locked   = lock_r || free_run(md);
  assign chk_en   = byte_vld && locked;
  assign exp_addr = pos;

  tti_align u_align (
    .clk(clk), .rst_n(rst_n), .vld(byte_vld), .data(byte_in), .md(md),
    .lock_r(lock_r), .pos(pos), .at_last(at_last), .msb_bad(msb_bad),
    .lock_set(lock_set), .lock_drop(lock_drop)
  );

  tti_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .vld(byte_vld), .data(byte_in),
    .exp_data(exp_data), .md(md), .at_last(at_last), .lock_set(lock_set),
    .byte_diff(byte_diff), .mm_clear(mm_clear), .mismatch(mismatch)
  );

  tti_capture u_cap (
    .clk(clk), .rst_n(rst_n), .wr_en(chk_en), .wr_addr(pos), .wr_data(byte_in),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/tti_monitor_sva.sv
module tti_monitor_sva
  import tti_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          byte_vld,
  input logic [BW-1:0] byte_in,
  input logic [2:0]    mode,
  input logic          lock_r,
  input logic          mismatch,
  input logic          msb_bad,
  input logic          byte_diff,
  input logic          chk_en,
  input logic          at_last
);
  assert_msb_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lock_r) && $past(mode) <= 3'd1) |-> $past(byte_vld && !byte_in[BW-1]));

  assert_msb_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && msb_bad) |=> !lock_r);

  assert_trailer_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lock_r) && $past(mode) == 3'd2) |-> $past(byte_in) == CH_LF);

  assert_diff_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && byte_diff) |=> mismatch);

  assert_clear_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mismatch) |-> $past(chk_en && at_last));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> ($stable(mismatch) && $stable(lock_r)));
endmodule

bind tti_monitor tti_monitor_sva i_sva (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
  .mode(mode), .lock_r(lock_r), .mismatch(mismatch), .msb_bad(msb_bad),
  .byte_diff(byte_diff), .chk_en(chk_en), .at_last(at_last)
);

// File: tb/test_tti_monitor.sv
module test_tti_monitor;
  localparam int CLK_P = 10;
  localparam int NCASE = 8;
  // {mode[2:0], fault position[7:0]}
  localparam logic [10:0] CASES [NCASE] = '{
    {3'd0, 8'd3},  {3'd0, 8'd15}, {3'd1, 8'd0},  {3'd1, 8'd63},
    {3'd2, 8'd0},  {3'd2, 8'd40}, {3'd3, 8'd7},  {3'd4, 8'd4}
  };

  logic       clk = 0;
  logic       rst_n = 0;
  logic       byte_vld = 0;
  logic [7:0] byte_in = 0;
  logic [2:0] mode = 0;
  logic [5:0] exp_addr;
  logic [7:0] exp_data;
  logic [5:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic       locked;
  logic       mismatch;
  logic [7:0] exp_mem [64];
  int         n_run = 0;
  int         n_fail = 0;

  always #(CLK_P/2) clk = ~clk;
  assign exp_data = exp_mem[exp_addr];

  tti_monitor i_tti_monitor (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .mode(mode), .exp_addr(exp_addr), .exp_data(exp_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .locked(locked), .mismatch(mismatch)
  );

  function automatic logic [7:0] mbyte(int m, int i);
    case (m)
      0: return (i == 0) ? 8'hC5 : 8'(8'h41 + i);
      1: return (i == 0) ? 8'hB3 : 8'(8'h20 + i);
      2: return (i == 62) ? 8'h0D : ((i == 63) ? 8'h0A : 8'(8'h30 + (i % 40)));
      3: return 8'h6B;
      default: return 8'h3C;
    endcase
  endfunction

  function automatic string lock_req(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(int m);
    @(negedge clk);
    rst_n = 0;
    byte_vld = 0;
    mode = 3'(m);
    for (int i = 0; i < 64; i++) exp_mem[i] = mbyte(m, i);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send(logic [7:0] b);
    byte_vld = 1;
    byte_in = b;
    @(negedge clk);
    byte_vld = 0;
    @(negedge clk);
  endtask

  task automatic send_msg(int m, int n);
    for (int i = 0; i < n; i++) send(mbyte(m, i));
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // Table walk: clean message, message with one fault, clean message
    for (int k = 0; k < NCASE; k++) begin
      int m;
      int c;
      int len;
      logic [7:0] b;
      m = int'(CASES[k][10:8]);
      c = int'(CASES[k][7:0]);
      len = (m == 1 || m == 2) ? 64 : 16;
      do_reset(m);
      send_msg(m, len);
      check(lock_req(m), 8'(locked), 8'd1);
      check("R7", 8'(exp_addr), 8'd0);
      check("R8", 8'(mismatch), 8'd0);
      for (int i = 0; i < len; i++) begin
        b = mbyte(m, i);
        if (i == c) b = b ^ 8'h01;
        send(b);
        if (i == c) check((m == 4) ? "R10" : "R7", 8'(mismatch), 8'd1);
      end
      check("R8", 8'(mismatch), 8'd1);
      rd_addr = 6'(c);
      #1;
      check("R11", rd_data, mbyte(m, c) ^ 8'h01);
      send_msg(m, len - 1);
      check("R8", 8'(mismatch), 8'd1);
      send(mbyte(m, len - 1));
      check("R8", 8'(mismatch), 8'd0);
    end

    // R1 reset state
    do_reset(0);
    check("R1", 8'(locked), 8'd0);
    check("R1", 8'(mismatch), 8'd0);
    rd_addr = 6'd3;
    #1;
    check("R1", rd_data, 8'h00);

    // R12 garbage while unlocked; R2 one short then lock; R4 bad top bit
    for (int i = 0; i < 10; i++) send(8'h11);
    check("R12", 8'(mismatch), 8'd0);
    check("R12", rd_data, 8'h00);
    send_msg(0, 15);
    check("R2", 8'(locked), 8'd0);
    send(mbyte(0, 15));
    check("R2", 8'(locked), 8'd1);
    send_msg(0, 5);
    send(8'hC0);
    check("R4", 8'(locked), 8'd0);

    // R3 64-byte lock boundary
    do_reset(1);
    send_msg(1, 63);
    check("R3", 8'(locked), 8'd0);
    send(mbyte(1, 63));
    check("R3", 8'(locked), 8'd1);

    // R5 trailer lock and first stored byte
    do_reset(2);
    for (int i = 0; i < 5; i++) send(8'h71);
    check("R5", 8'(locked), 8'd0);
    send(8'h0D);
    send(8'h0A);
    check("R5", 8'(locked), 8'd1);
    send(8'h77);
    rd_addr = 6'd0;
    #1;
    check("R5", rd_data, 8'h77);
    check("R7", 8'(exp_addr), 8'd1);

    // R6 broken trailer drops lock
    do_reset(2);
    send_msg(2, 64);
    check("R6", 8'(locked), 8'd1);
    send_msg(2, 62);
    check("R6", 8'(locked), 8'd1);
    send(8'h5A);
    check("R6", 8'(locked), 8'd0);

    // R9 fixed byte: locked from reset, positions advance
    do_reset(3);
    check("R9", 8'(locked), 8'd1);
    send_msg(3, 3);
    check("R9", 8'(exp_addr), 8'd3);
    check("R9", 8'(mismatch), 8'd0);

    // R10 free byte: first byte has no predecessor
    do_reset(4);
    send(8'hA5);
    check("R10", 8'(mismatch), 8'd0);
    send(8'hA4);
    check("R10", 8'(mismatch), 8'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule